// File: doc/BRIEF.md
# Fractional-prescaled microsecond timer

This block keeps a free-running microsecond count while running from a fast reference clock of any frequency. A 16-bit ratio register holds two byte fields, a numerator field N and a denominator field M. The reference clock is divided by the rational number (N+1)/(M+1). A phase accumulator does the division: on each enabled reference cycle it adds M+1, and whenever the sum reaches N+1 it removes N+1 and issues one tick. Because of this, frequencies that are not whole megahertz, such as 19.2 MHz (ratio word 0x045F) or 38.4 MHz (0x04BF), still produce an average of exactly one tick per microsecond, with no long-term drift.

Each tick advances a counter that wraps. Software reads the counter and the ratio, and writes the ratio, through a small register port with byte offsets. Read data comes back one cycle after the strobe. An external enable input freezes both the counter and the accumulator phase while it is low.

Top module: `usec_tick_timer`

## Requirements
- R1: After reset the count reads 0 and the ratio register reads 0x000C, which means N=12 and M=0 (divide the reference clock by 13).
- R2: The ratio word holds N in bits [7:0] and M in bits [15:8]. When M<=N, starting from a clean phase, K enabled cycles with no ratio write produce exactly floor(K*(M+1)/(N+1)) ticks.
- R3: When M>N, exactly one tick is issued on every enabled cycle. The excess phase is carried forward but is limited to 511.
- R4: While `tmr_en` is low, the count and the accumulator phase both hold. Counting resumes from the same phase when `tmr_en` returns high.
- R5: A write to offset 0x4 loads `reg_wdata` into the ratio register and clears the phase. In that cycle the prescaler does not advance, even if `tmr_en` is high.
- R6: The count is CNT_W bits wide. On the next tick it wraps from all ones to 0, with no saturation.
- R7: A read strobe at clock edge t sets `rd_valid` high for exactly the one cycle after t. `rd_data` then holds the value the register had just before edge t.
- R8: Offset 0x0 reads the count, zero-extended to 32 bits. Offset 0x4 reads the ratio, zero-extended. Any other offset reads 0. Writes to offset 0x0 or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Counting enable; holds count and phase when low |
| reg_addr | input | ADDR_W (4) | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data (ratio word) |
| reg_rd | input | 1 | Read strobe |
| rd_data | output | DATA_W (32) | Read data, valid one cycle after the strobe |
| rd_valid | output | 1 | Marks the cycle in which rd_data is valid |

## Verification
The bench targets each ratio example, counting ticks over one full repeat period. A design that swapped the N and M fields, or that used N instead of N+1, would give a tick count that is off by several over that window. It stops `tmr_en` partway through a period and checks that the later total still equals the figure for a whole period; a design that lost its phase while halted would drop or gain a tick. It writes the ratio while `tmr_en` is high, and drives a ratio below one, where a design that emitted several ticks per cycle or overflowed its accumulator would jump or stall. A narrow-counter copy crosses all ones, and a saturating counter would stick there.

// File: rtl/utmr_pkg.sv
package utmr_pkg;

    localparam int FLD_W = 8;
    localparam int CFG_W = 2 * FLD_W;

    typedef struct packed {
        logic [FLD_W-1:0] den_f;   // M, bits [15:8]
        logic [FLD_W-1:0] num_f;   // N, bits [7:0]
    } ratio_t;

    localparam logic [CFG_W-1:0] RATIO_RST = 16'h000C;

    localparam int OFS_COUNT = 0;
    localparam int OFS_RATIO = 4;

endpackage

// File: rtl/utmr_prescaler.sv
module utmr_prescaler
    import utmr_pkg::*;
#(
    parameter int ACC_W = FLD_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  ratio_t           ratio,
    output logic             tick,
    output logic [ACC_W-1:0] phase
);
    localparam int SW = ACC_W + 1;
    localparam logic [SW-1:0] PH_MAX = SW'((1 << (ACC_W - 1)) - 1);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } ps_state_t;

    ps_state_t st_q, st_d;
    logic      tick_d;

    logic [SW-1:0] sum_w;
    logic [SW-1:0] step_w;
    logic [SW-1:0] rem_w;

    always_comb begin
        st_d   = st_q;
        tick_d = 1'b0;
        sum_w  = SW'(st_q.acc) + SW'(ratio.den_f) + SW'(1);
        step_w = SW'(ratio.num_f) + SW'(1);
        rem_w  = sum_w;
        if (clr) begin
            st_d.acc = '0;
        end else if (run) begin
            if (sum_w >= step_w) begin
                rem_w  = sum_w - step_w;
                tick_d = 1'b1;
            end
            if (rem_w > PH_MAX) begin
                rem_w = PH_MAX;
            end
            st_d.acc = rem_w[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick  = tick_d;
    assign phase = st_q.acc;

endmodule

// File: rtl/utmr_counter.sv
module utmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cn_state_t;

    cn_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (inc) begin
            st_d.val = st_q.val + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.val;

endmodule

// File: rtl/utmr_regs.sv
module utmr_regs
    import utmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [CFG_W-1:0]  wdata,
    input  logic              rd,
    input  logic [CNT_W-1:0]  count,
    output ratio_t            ratio,
    output logic              ratio_wr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_RAT = ADDR_W'(OFS_RATIO);

    typedef struct packed {
        ratio_t            ratio;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } rg_state_t;

    rg_state_t         st_q, st_d;
    logic              hit_cnt, hit_rat;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        hit_cnt  = (addr == A_CNT);
        hit_rat  = (addr == A_RAT);
        ratio_wr = wr && hit_rat;
        rd_mux   = '0;
        if (hit_cnt) begin
            rd_mux = DATA_W'(count);
        end else if (hit_rat) begin
            rd_mux = DATA_W'(st_q.ratio);
        end
        st_d        = st_q;
        st_d.rvalid = rd;
        if (rd) begin
            st_d.rdata = rd_mux;
        end
        if (ratio_wr) begin
            st_d.ratio = ratio_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ratio  <= ratio_t'(RATIO_RST);
            st_q.rdata  <= '0;
            st_q.rvalid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio  = st_q.ratio;
    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;

endmodule

// File: rtl/usec_tick_timer.sv
module usec_tick_timer
    import utmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CFG_W-1:0]  reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int ACC_W = FLD_W + 2;

    ratio_t           ratio_w;
    logic             ratio_wr_w;
    logic             tick_w;
    logic [ACC_W-1:0] phase_w;
    logic [CNT_W-1:0] count_w;

    utmr_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .rd      (reg_rd),
        .count   (count_w),
        .ratio   (ratio_w),
        .ratio_wr(ratio_wr_w),
        .rdata   (rd_data),
        .rvalid  (rd_valid)
    );

    utmr_prescaler #(
        .ACC_W(ACC_W)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (tmr_en),
        .clr  (ratio_wr_w),
        .ratio(ratio_w),
        .tick (tick_w),
        .phase(phase_w)
    );

    utmr_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (tick_w),
        .count(count_w)
    );

endmodule

// File: rtl/utmr_checker.sv
module utmr_checker
    import utmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int ACC_W = FLD_W + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_en,
    input logic             reg_rd,
    input logic             rd_valid,
    input logic             ratio_wr,
    input logic             tick,
    input logic [ACC_W-1:0] phase,
    input logic [CNT_W-1:0] count,
    input ratio_t           ratio
);
    // R4: no tick without enable
    a_r4_tick_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> tmr_en);

    // R4: halted enable freezes count and phase
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |=> ($stable(count) && $stable(phase)));

    // R5: ratio write leaves a clean phase and no tick
    a_r5_clean_phase: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_wr |=> (phase == '0 && $stable(count)));

    // R6: a tick adds exactly one, modulo the width
    a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + CNT_W'(1)));

    // R2: count moves only on ticks
    a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    // R2: phase residue stays below N+1 when M<=N
    a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio.den_f <= ratio.num_f) |->
            (phase < ACC_W'(ratio.num_f) + ACC_W'(1)));

    // R3: ratio below one ticks on every enabled cycle
    a_r3_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && !ratio_wr && ratio.den_f > ratio.num_f) |-> tick);

    // R7: read data marked valid exactly one cycle after the strobe
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> rd_valid);
    a_r7_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !rd_valid);

endmodule

bind usec_tick_timer utmr_checker #(
    .CNT_W(CNT_W),
    .ACC_W(ACC_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tmr_en  (tmr_en),
    .reg_rd  (reg_rd),
    .rd_valid(rd_valid),
    .ratio_wr(ratio_wr_w),
    .tick    (tick_w),
    .phase   (phase_w),
    .count   (count_w),
    .ratio   (ratio_w)
);

// File: tb/sim_usec_tick_timer.sv
`timescale 1ns/100ps
module sim_usec_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] rd_data, rd_data8;
    logic        rd_valid, rd_valid8;

    int total = 0;
    int bad = 0;

    // behavioural model state
    longint m_cnt = 0;
    int     m_acc = 0;
    int     m_ratio = 'h000C;
    logic [31:0] exp_d, exp_d8;
    logic        exp_v;
    logic [31:0] last_rd, last_rd8;

    always #2.5 clk = ~clk;

    usec_tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    usec_tick_timer #(.CNT_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .rd_data(rd_data8), .rd_valid(rd_valid8)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a, input int w);
        if (a == 4'h0) return 32'((m_cnt) & ((64'd1 << w) - 1));
        if (a == 4'h4) return 32'(m_ratio);
        return 32'd0;
    endfunction

    task automatic step(input logic en, input logic wr, input logic rd,
                        input logic [3:0] a, input logic [15:0] wd);
        int n1, m1, s;
        tmr_en = en; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        @(posedge clk);
        exp_v = rd;
        if (rd) begin
            exp_d  = model_read(a, 32);
            exp_d8 = model_read(a, 8);
        end
        if (wr && a == 4'h4) begin
            m_ratio = int'(wd);
            m_acc = 0;
        end else if (en) begin
            n1 = (m_ratio & 'hFF) + 1;
            m1 = ((m_ratio >> 8) & 'hFF) + 1;
            s = m_acc + m1;
            if (s >= n1) begin
                s = s - n1;
                m_cnt++;
            end
            m_acc = (s > 511) ? 511 : s;
        end
        #1;
        check("R7 valid", {31'd0, rd_valid}, {31'd0, exp_v});
        check("R7 valid narrow", {31'd0, rd_valid8}, {31'd0, exp_v});
        if (exp_v) begin
            check("R7/R8 data", rd_data, exp_d);
            check("R6/R8 data narrow", rd_data8, exp_d8);
            last_rd  = rd_data;
            last_rd8 = rd_data8;
        end
    endtask

    task automatic run(input int k);
        for (int i = 0; i < k; i++) step(1'b1, 1'b0, 1'b0, 4'h0, 16'h0);
    endtask

    task automatic rd_cnt;
        step(1'b0, 1'b0, 1'b1, 4'h0, 16'h0);
    endtask

    task automatic set_ratio(input logic [15:0] r);
        step(1'b1, 1'b1, 1'b0, 4'h4, r);
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] base;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_cnt;
        check("R1 count", last_rd, 32'd0);
        step(1'b0, 1'b0, 1'b1, 4'h4, 16'h0);
        check("R1 ratio", last_rd, 32'h0000_000C);

        // R2 default divide by 13
        run(130);
        rd_cnt;
        check("R2 div13", last_rd, 32'd10);

        // R2/R5 12 MHz, written while enabled
        base = last_rd;
        set_ratio(16'h000B);
        run(120);
        rd_cnt;
        check("R2/R5 ratio 0x000B", last_rd - base, 32'd10);

        // R2 19.2 MHz
        base = last_rd;
        set_ratio(16'h045F);
        step(1'b0, 1'b0, 1'b1, 4'h4, 16'h0);
        check("R8 ratio readback", last_rd, 32'h0000_045F);
        run(96);
        rd_cnt;
        check("R2 ratio 0x045F", last_rd - base, 32'd5);

        // R2/R4 38.4 MHz with a halt in the middle
        base = last_rd;
        set_ratio(16'h04BF);
        run(50);
        for (int i = 0; i < 100; i++) step(1'b0, 1'b0, (i % 7) == 0, 4'h0, 16'h0);
        rd_cnt;
        check("R4 halt keeps count", last_rd - base, 32'd1);
        run(142);
        rd_cnt;
        check("R2/R4 ratio 0x04BF phase kept", last_rd - base, 32'd5);

        // R3 ratio below one
        base = last_rd;
        set_ratio(16'h0300);
        run(40);
        rd_cnt;
        check("R3 one tick per cycle", last_rd - base, 32'd40);
        base = last_rd;
        set_ratio(16'h0005);
        run(12);
        rd_cnt;
        check("R3/R5 phase cleared after fast ratio", last_rd - base, 32'd2);

        // R8 ignored writes and unmapped reads
        base = last_rd;
        step(1'b0, 1'b1, 1'b0, 4'h0, 16'h1234);
        step(1'b0, 1'b1, 1'b0, 4'h8, 16'h0300);
        rd_cnt;
        check("R8 write to count ignored", last_rd, base);
        step(1'b0, 1'b0, 1'b1, 4'h4, 16'h0);
        check("R8 unmapped write ignored", last_rd, 32'h0000_0005);
        step(1'b0, 1'b0, 1'b1, 4'h8, 16'h0);
        check("R8 unmapped read", last_rd, 32'd0);
        step(1'b0, 1'b0, 1'b1, 4'hC, 16'h0);
        check("R8 unmapped read C", last_rd, 32'd0);

        // R7 back-to-back reads while counting
        set_ratio(16'h0000);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b1, 4'h0, 16'h0);

        // R6 wrap of the narrow counter
        rd_cnt;
        base = last_rd8;
        run(256 - int'(base) + 3);
        rd_cnt;
        check("R6 narrow wrap", last_rd8, 32'd3);

        // mixed traffic
        set_ratio(16'h0453);
        for (int i = 0; i < 300; i++)
            step((i % 5) != 0, 1'b0, (i % 3) == 0, (i % 9 == 0) ? 4'h4 : 4'h0, 16'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule